// File: doc/BRIEF.md
# Hamming Single-Error Corrector

This block holds two independent paths that share a clock: an encoder that turns a data word into a single-error-correcting Hamming codeword, and a decoder that takes a possibly damaged codeword, finds and repairs a single flipped bit, and returns the data. Codeword positions are counted from 1. Check bits sit at the positions that are powers of two, and data bits fill the other positions in ascending order. Codeword position p is carried on bit p-1 of a codeword port.

The decoder recomputes every check over the received word, including the received check bit. The check results, with the check for position 1 as the least significant bit, form a syndrome equal to the index of the damaged position. The decoder flips that position, extracts the data and reports the syndrome. A syndrome that points beyond the end of the codeword cannot come from a single error; such a word is flagged as uncorrectable and its data is passed on without any flip.

The data width is a parameter (default 4). The check-bit count is derived from it, so each path has a fixed width per instance. Each path has its own valid input, and every output is registered with one cycle of latency.

Top module: `hamSecCodec`

## Requirements
- R1: The check-bit count r is the smallest integer with 2^r >= DATA_W + r + 1, and the codeword is DATA_W + r bits wide (7 bits for 4 data bits, 9 bits for 5).
- R2: The encoder puts data bit i at the (i+1)-th codeword position that is not a power of two, counting up from position 1; position p appears on bit p-1 of `encWord`.
- R3: The check bit at position 2^j is set so that the XOR of all codeword positions whose index has bit j set is 0 (even parity); for 4 data bits, data 1010 gives codeword 1010010.
- R4: `decPos` carries the syndrome, with bit j equal to the XOR of the received positions whose index has bit j set; `decErr` is 1 exactly when the syndrome is nonzero.
- R5: A codeword with any one position inverted decodes to the original data, with `decPos` equal to that position (received 1110010 gives position 6; with 5 data bits a flip at position 5 gives position 5).
- R6: A valid codeword decodes to its data with `decErr` = 0, `decPos` = 0 and `decUncorr` = 0.
- R7: When the syndrome is greater than the codeword length, `decUncorr` and `decErr` are 1 and `decData` is the data taken from the received word with no bit inverted.
- R8: Results appear on the outputs at the first rising clock edge after the inputs are presented with their valid high; `encOutValid` and `decOutValid` are the valid inputs delayed by one cycle.
- R9: While a path's valid input is low, that path's data outputs keep their previous values and its output valid is 0.
- R10: While `rstN` is low, every output is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Asynchronous reset, active low |
| encValid | input | 1 | Encoder input is valid this cycle |
| encData | input | DATA_W | Data word to encode |
| decValid | input | 1 | Decoder input is valid this cycle |
| decWord | input | DATA_W+r | Received codeword, position p on bit p-1 |
| encOutValid | output | 1 | `encWord` was updated at the last edge |
| encWord | output | DATA_W+r | Encoded codeword |
| decOutValid | output | 1 | Decoder outputs were updated at the last edge |
| decData | output | DATA_W | Corrected data |
| decErr | output | 1 | Syndrome was nonzero |
| decPos | output | r | Syndrome, index of the damaged position |
| decUncorr | output | 1 | Syndrome beyond the codeword length |

## Verification
The only state is the output registers and the two valid flops, so a wrong internal value shows at the ports one edge after the input that produced it and stays there until the next valid input on that path. A wrong coverage mask for one check bit shows as a wrong check bit on `encWord` for data patterns that touch that mask, and as a wrong `decPos` for every flip at a position the mask covers. A broken hold or valid path shows as an output that changes, or a valid flag that is set, on a cycle whose input valid was low. The uncorrectable case needs a syndrome above the codeword length, which needs at least 5 data bits, so a second instance with that width is driven with a double flip at two check positions.

// File: rtl/hamSecPkg.sv
package hamSecPkg;

  // Smallest check-bit count r with 2^r >= d + r + 1
  function automatic int parCount(input int dataW);
    int r;
    r = 1;
    while ((1 << r) < dataW + r + 1) r++;
    return r;
  endfunction

  typedef struct packed {
    logic capEnc;
    logic capDec;
  } hamStrobeT;

endpackage

// File: rtl/hamSecCtrl.sv
module hamSecCtrl
  import hamSecPkg::*;
(
  input  logic      clk,
  input  logic      rstN,
  input  logic      encValid,
  input  logic      decValid,
  output hamStrobeT stb,
  output logic      encOutValid,
  output logic      decOutValid
);

  always_comb begin
    stb.capEnc = encValid;
    stb.capDec = decValid;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      encOutValid <= 1'b0;
      decOutValid <= 1'b0;
    end else begin
      encOutValid <= encValid;
      decOutValid <= decValid;
    end
  end

endmodule

// File: rtl/hamSecPath.sv
module hamSecPath
  import hamSecPkg::*;
#(
  parameter int DATA_W = 4,
  parameter int PAR_W  = 3,
  parameter int CODE_W = 7
) (
  input  logic              clk,
  input  logic              rstN,
  input  hamStrobeT         stb,
  input  logic [DATA_W-1:0] encData,
  input  logic [CODE_W-1:0] decWord,
  output logic [CODE_W-1:0] encWord,
  output logic [DATA_W-1:0] decData,
  output logic              decErr,
  output logic [PAR_W-1:0]  decPos,
  output logic              decUncorr
);

  localparam logic [PAR_W:0] LAST_POS = (PAR_W+1)'(CODE_W);

  // Positions (1-based) whose index has bit j set
  function automatic logic [CODE_W-1:0] coverMask(input int j);
    logic [CODE_W-1:0] m;
    for (int p = 1; p <= CODE_W; p++) m[p-1] = ((p >> j) & 1) == 1;
    return m;
  endfunction

  function automatic logic isPow2(input int p);
    return (p & (p - 1)) == 0;
  endfunction

  function automatic logic [CODE_W-1:0] placeData(input logic [DATA_W-1:0] d);
    logic [CODE_W-1:0] w;
    int k;
    w = '0;
    k = 0;
    for (int p = 1; p <= CODE_W; p++) begin
      if (!isPow2(p)) begin
        w[p-1] = d[k];
        k++;
      end
    end
    return w;
  endfunction

  function automatic logic [DATA_W-1:0] pullData(input logic [CODE_W-1:0] w);
    logic [DATA_W-1:0] d;
    int k;
    d = '0;
    k = 0;
    for (int p = 1; p <= CODE_W; p++) begin
      if (!isPow2(p)) begin
        d[k] = w[p-1];
        k++;
      end
    end
    return d;
  endfunction

  logic [CODE_W-1:0] placedWord;
  logic [CODE_W-1:0] encNext;
  logic [PAR_W-1:0]  encPar;
  logic [PAR_W-1:0]  syndrome;
  logic [CODE_W-1:0] flipMask;
  logic [CODE_W-1:0] fixedWord;
  logic              synBeyond;

  assign placedWord = placeData(encData);

  generate
    for (genvar j = 0; j < PAR_W; j++) begin : g_check
      localparam logic [CODE_W-1:0] MASK_J = coverMask(j);
      assign encPar[j]   = ^(placedWord & MASK_J);
      assign syndrome[j] = ^(decWord & MASK_J);
    end
  endgenerate

  always_comb begin
    encNext = placedWord;
    for (int j = 0; j < PAR_W; j++) encNext[(1 << j) - 1] = encPar[j];
  end

  assign synBeyond = {1'b0, syndrome} > LAST_POS;

  always_comb begin
    for (int p = 1; p <= CODE_W; p++) flipMask[p-1] = (syndrome == PAR_W'(p));
  end

  assign fixedWord = decWord ^ flipMask;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      encWord   <= '0;
      decData   <= '0;
      decErr    <= 1'b0;
      decPos    <= '0;
      decUncorr <= 1'b0;
    end else begin
      if (stb.capEnc) encWord <= encNext;
      if (stb.capDec) begin
        decData   <= pullData(fixedWord);
        decErr    <= |syndrome;
        decPos    <= syndrome;
        decUncorr <= synBeyond;
      end
    end
  end

endmodule

// File: rtl/hamSecCodec.sv
module hamSecCodec
  import hamSecPkg::*;
#(
  parameter  int DATA_W = 4,
  localparam int PAR_W  = parCount(DATA_W),
  localparam int CODE_W = DATA_W + PAR_W
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              encValid,
  input  logic [DATA_W-1:0] encData,
  input  logic              decValid,
  input  logic [CODE_W-1:0] decWord,
  output logic              encOutValid,
  output logic [CODE_W-1:0] encWord,
  output logic              decOutValid,
  output logic [DATA_W-1:0] decData,
  output logic              decErr,
  output logic [PAR_W-1:0]  decPos,
  output logic              decUncorr
);

  hamStrobeT stb;

  hamSecCtrl u_ctrl (
    .clk        (clk),
    .rstN       (rstN),
    .encValid   (encValid),
    .decValid   (decValid),
    .stb        (stb),
    .encOutValid(encOutValid),
    .decOutValid(decOutValid)
  );

  hamSecPath #(
    .DATA_W(DATA_W),
    .PAR_W (PAR_W),
    .CODE_W(CODE_W)
  ) u_path (
    .clk      (clk),
    .rstN     (rstN),
    .stb      (stb),
    .encData  (encData),
    .decWord  (decWord),
    .encWord  (encWord),
    .decData  (decData),
    .decErr   (decErr),
    .decPos   (decPos),
    .decUncorr(decUncorr)
  );

endmodule

// File: rtl/hamSecChk.sv
module hamSecChk #(
  parameter int DATA_W = 4,
  parameter int PAR_W  = 3,
  parameter int CODE_W = 7
) (
  input logic              clk,
  input logic              rstN,
  input logic              encValid,
  input logic              decValid,
  input logic              encOutValid,
  input logic [CODE_W-1:0] encWord,
  input logic              decOutValid,
  input logic [DATA_W-1:0] decData,
  input logic              decErr,
  input logic [PAR_W-1:0]  decPos,
  input logic              decUncorr
);

  AST_ENC_VALID_DELAY: assert property (@(posedge clk) disable iff (!rstN)
    encValid |=> encOutValid); // R8
  AST_DEC_VALID_DELAY: assert property (@(posedge clk) disable iff (!rstN)
    decValid |=> decOutValid); // R8
  AST_ENC_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    !encValid |=> (!encOutValid && $stable(encWord))); // R9
  AST_DEC_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    !decValid |=> (!decOutValid && $stable(decData) && $stable(decPos) && $stable(decErr))); // R9
  AST_ERR_MATCHES_POS: assert property (@(posedge clk) disable iff (!rstN)
    decErr == (decPos != '0)); // R4
  AST_UNCORR_IS_ERR: assert property (@(posedge clk) disable iff (!rstN)
    decUncorr |-> decErr); // R7
  AST_UNCORR_RANGE: assert property (@(posedge clk) disable iff (!rstN)
    decUncorr |-> (int'(decPos) > CODE_W)); // R7

endmodule

bind hamSecCodec hamSecChk #(
  .DATA_W(DATA_W),
  .PAR_W (PAR_W),
  .CODE_W(CODE_W)
) u_chk (
  .clk        (clk),
  .rstN       (rstN),
  .encValid   (encValid),
  .decValid   (decValid),
  .encOutValid(encOutValid),
  .encWord    (encWord),
  .decOutValid(decOutValid),
  .decData    (decData),
  .decErr     (decErr),
  .decPos     (decPos),
  .decUncorr  (decUncorr)
);

// File: tb/hamSecCodec_bench.sv
module hamSecCodec_bench;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  always #10 clk = ~clk;

  int tests = 0;
  int fails = 0;

  // Default instance: 4 data bits, 7-bit codeword
  logic       encValid = 0, decValid = 0;
  logic [3:0] encData = '0;
  logic [6:0] decWord = '0;
  logic       encOutValid, decOutValid, decErr, decUncorr;
  logic [6:0] encWord;
  logic [3:0] decData;
  logic [2:0] decPos;

  hamSecCodec u_hamSecCodec (
    .clk(clk), .rstN(rstN),
    .encValid(encValid), .encData(encData),
    .decValid(decValid), .decWord(decWord),
    .encOutValid(encOutValid), .encWord(encWord),
    .decOutValid(decOutValid), .decData(decData),
    .decErr(decErr), .decPos(decPos), .decUncorr(decUncorr)
  );

  // Wider instance: 5 data bits, 9-bit codeword
  logic       w5EncValid = 0, w5DecValid = 0;
  logic [4:0] w5EncData = '0;
  logic [8:0] w5DecWord = '0;
  logic       w5EncOutValid, w5DecOutValid, w5DecErr, w5DecUncorr;
  logic [8:0] w5EncWord;
  logic [4:0] w5DecData;
  logic [3:0] w5DecPos;

  hamSecCodec #(.DATA_W(5)) u_hamSecCodecW5 (
    .clk(clk), .rstN(rstN),
    .encValid(w5EncValid), .encData(w5EncData),
    .decValid(w5DecValid), .decWord(w5DecWord),
    .encOutValid(w5EncOutValid), .encWord(w5EncWord),
    .decOutValid(w5DecOutValid), .decData(w5DecData),
    .decErr(w5DecErr), .decPos(w5DecPos), .decUncorr(w5DecUncorr)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  typedef struct packed {
    logic       isDec;
    logic [6:0] stim;
    logic [6:0] expA;
    logic       expErr;
    logic [2:0] expPos;
  } vecT;

  // Encode rows: stim[3:0] data -> expA codeword. Decode rows: stim received -> expA[3:0] data.
  localparam vecT VECS [12] = '{
    '{1'b0, 7'b0000000, 7'b0000000, 1'b0, 3'd0},
    '{1'b0, 7'b0001010, 7'b1010010, 1'b0, 3'd0},
    '{1'b0, 7'b0001111, 7'b1111111, 1'b0, 3'd0},
    '{1'b0, 7'b0000001, 7'b0000111, 1'b0, 3'd0},
    '{1'b0, 7'b0000110, 7'b0110011, 1'b0, 3'd0},
    '{1'b0, 7'b0001000, 7'b1001011, 1'b0, 3'd0},
    '{1'b1, 7'b1010010, 7'b0001010, 1'b0, 3'd0},
    '{1'b1, 7'b1110010, 7'b0001010, 1'b1, 3'd6},
    '{1'b1, 7'b0000001, 7'b0000000, 1'b1, 3'd1},
    '{1'b1, 7'b0111111, 7'b0001111, 1'b1, 3'd7},
    '{1'b1, 7'b0110111, 7'b0000110, 1'b1, 3'd3},
    '{1'b1, 7'b1000011, 7'b0001000, 1'b1, 3'd4}
  };

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    fails++;
    tests++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin : main
    // R10: outputs zero during reset
    repeat (2) @(negedge clk);
    chk("R10 encWord", 32'(encWord), 0);
    chk("R10 dec", {decOutValid, encOutValid, decErr, decUncorr, decPos, decData}, 0);
    // R1: derived widths
    chk("R1 width d4", $bits(encWord), 7);
    chk("R1 width d5", $bits(w5EncWord), 9);
    chk("R1 pos width d5", $bits(w5DecPos), 4);
    rstN = 1'b1;

    // Table walk
    for (int i = 0; i < 12; i++) begin
      @(negedge clk);
      if (VECS[i].isDec) begin
        decWord = VECS[i].stim; decValid = 1'b1;
      end else begin
        encData = VECS[i].stim[3:0]; encValid = 1'b1;
      end
      @(negedge clk);
      if (VECS[i].isDec) begin
        chk("R8 decOutValid", 32'(decOutValid), 1);
        chk(VECS[i].expErr ? "R5 data" : "R6 data", 32'(decData), 32'(VECS[i].expA[3:0]));
        chk("R4 decPos", 32'(decPos), 32'(VECS[i].expPos));
        chk("R4 decErr", 32'(decErr), 32'(VECS[i].expErr));
        chk("R6 decUncorr", 32'(decUncorr), 0);
        decValid = 1'b0;
      end else begin
        chk("R8 encOutValid", 32'(encOutValid), 1);
        chk("R2 R3 encWord", 32'(encWord), 32'(VECS[i].expA));
        encValid = 1'b0;
      end
      @(negedge clk);
      chk("R9 valids low", {encOutValid, decOutValid}, 0);
    end

    // R9: inputs changed with valid low leave outputs alone (last: enc 1001011, dec data 1000 pos 4)
    encData = 4'b0110; decWord = 7'b1110010;
    @(negedge clk); @(negedge clk);
    chk("R9 encWord held", 32'(encWord), 32'(7'b1001011));
    chk("R9 decData held", 32'(decData), 32'(4'b1000));
    chk("R9 decPos held", 32'(decPos), 4);

    // R8: before the edge the output still shows the old result
    encData = 4'b1010; encValid = 1'b1;
    #1 chk("R8 not before edge", 32'(encWord), 32'(7'b1001011));
    @(negedge clk);
    chk("R8 after edge", 32'(encWord), 32'(7'b1010010));
    encValid = 1'b0;

    // Wider instance: encode 11011 -> 111010100 (R2, R3)
    w5EncData = 5'b11011; w5EncValid = 1'b1;
    @(negedge clk);
    chk("R3 d5 encWord", 32'(w5EncWord), 32'(9'b111010100));
    w5EncValid = 1'b0;
    // R5: flip at position 5
    w5DecWord = 9'b111000100; w5DecValid = 1'b1;
    @(negedge clk);
    chk("R5 d5 data", 32'(w5DecData), 32'(5'b11011));
    chk("R5 d5 pos", 32'(w5DecPos), 5);
    chk("R5 d5 uncorr", 32'(w5DecUncorr), 0);
    // R7: flips at positions 2 and 8 -> syndrome 10 > 9
    w5DecWord = 9'b101010110;
    @(negedge clk);
    chk("R7 uncorr", 32'(w5DecUncorr), 1);
    chk("R7 err", 32'(w5DecErr), 1);
    chk("R7 pos", 32'(w5DecPos), 10);
    chk("R7 data raw", 32'(w5DecData), 32'(5'b11011));
    // R7: data bits damaged with syndrome out of range are passed raw (positions 3 and 8 -> 11 > 9)
    w5DecWord = 9'b111010100 ^ 9'b010000100;
    @(negedge clk);
    chk("R7 raw pass", 32'(w5DecData), 32'(5'b11010));
    chk("R7 pos 11", 32'(w5DecPos), 11);
    w5DecValid = 1'b0;

    // R10: reset in mid-run clears everything
    @(negedge clk);
    rstN = 1'b0;
    #1;
    chk("R10 mid encWord", 32'(encWord), 0);
    chk("R10 mid dec", {w5DecErr, w5DecUncorr, w5DecPos, w5DecData, decData, decPos}, 0);
    @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

endmodule